// File: doc/BRIEF.md
# Banked Input Change Interrupt Monitor

This block watches a wide vector of general-purpose pins, grouped into eight-bit banks, and reports two things to the surrounding register logic. The first is the read-back value of every pin, after a two-flop synchroniser and a per-bit optional inversion. The pin level is returned whether the line is currently set up as an input or as an output. The second is an active-low interrupt that is pulled low when a line set up as an input and not masked differs from a per-bank reference snapshot.

The register file supplies the direction, mask and inversion vectors. It pulses one read strobe per bank whenever software reads that bank's input value. A read strobe copies the bank's current synchronised levels into its snapshot, which removes that bank's contribution to the interrupt. A line that changes and then returns to its snapshot value before any read withdraws its own change. The interrupt output models an open-drain pin: 0 means the line is pulled low and 1 means it is released.

Top module: `pin_watch_irq`

## Requirements
- R1: `rd_data_o[i]` equals the synchronised level of `pin_i[i]` when `inv_i[i]` is 0 and its complement when `inv_i[i]` is 1, whatever the value of `dir_in_i[i]`; a change of `inv_i` shows on `rd_data_o` in the same cycle.
- R2: A pin change applied between two rising edges reaches `rd_data_o` after the second rising edge that follows it, because of two synchronising flops.
- R3: `irq_n_o` is active low. It goes to 0 on the third rising edge after an unmasked, input-configured line (`dir_in_i[i]`=1, `mask_i[i]`=0) changes away from its snapshot value.
- R4: A line with `dir_in_i[i]`=0 (configured as output) never drives `irq_n_o` low, however its pin toggles.
- R5: A line with `mask_i[i]`=1 never drives `irq_n_o` low. Masking does not refresh the snapshot, so clearing the mask bit while that line still differs from its snapshot drives `irq_n_o` low on the next rising edge.
- R6: A one-cycle pulse on `rd_bank_i[b]` loads the snapshot of bank b (pin bits 8b to 8b+7) from the synchronised levels at that edge. If no other bank has a pending change, `irq_n_o` returns to 1 on the following rising edge.
- R7: A read strobe for one bank leaves the pending changes of every other bank in place, so `irq_n_o` stays 0 while any other bank still has one.
- R8: If a changed line returns to its snapshot value before its bank is read, its change condition is withdrawn, and `irq_n_o` returns to 1 three rising edges after the return.
- R9: While `rst_n` is low (held for at least three cycles with stable pins), the snapshots load from the synchronised inputs and `irq_n_o` is 1. After release, `irq_n_o` stays 1 until some pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 40 | Raw pin levels, bank b on bits 8b..8b+7 |
| dir_in_i | input | 40 | 1 = line configured as input |
| mask_i | input | 40 | 1 = line excluded from interrupt generation |
| inv_i | input | 40 | 1 = read-back of that line is inverted |
| rd_bank_i | input | 5 | One-cycle read strobe per bank |
| rd_data_o | output | 40 | Synchronised, polarity-adjusted pin levels |
| irq_n_o | output | 1 | Interrupt, 0 = pulled low, 1 = released |

## Verification
The bench times each pin change to the exact cycle. A design with one synchroniser stage too many or too few shows the new level or the interrupt one cycle early or late. It reads one bank while a second bank still has a pending change; a design that cleared all banks on any read would release the interrupt too soon. It toggles output-configured and masked lines, then clears a mask while the line still differs from its snapshot; a design that refreshed the snapshot while masked would stay silent. A line that changes and then reverts without a read must release the interrupt by itself, and a design that latched changes would hold it low until a read.

// File: rtl/giw_pkg.sv
package giw_pkg;

  localparam int unsigned GIW_WORD_W = 64;

  // Level seen by a reader: the synchronised level with the per-bit inversion applied.
  function automatic logic [GIW_WORD_W-1:0] f_visible(
    input logic [GIW_WORD_W-1:0] lvl,
    input logic [GIW_WORD_W-1:0] inv
  );
    return lvl ^ inv;
  endfunction

  // Lines that may raise the interrupt: they differ from the snapshot, face inward and are not masked.
  function automatic logic [GIW_WORD_W-1:0] f_armed(
    input logic [GIW_WORD_W-1:0] lvl,
    input logic [GIW_WORD_W-1:0] snap,
    input logic [GIW_WORD_W-1:0] dir_in,
    input logic [GIW_WORD_W-1:0] mask
  );
    return (lvl ^ snap) & dir_in & ~mask;
  endfunction

endpackage

// File: rtl/giw_pin_sync.sv
module giw_pin_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // The synchroniser keeps running during reset, so the snapshots can load settled levels.
  always_ff @(posedge clk) begin
    stage1_q <= pin_i;
    stage2_q <= stage1_q;
  end

  assign lvl_o = stage2_q;

  // R2: two stages between the pin and the compared level
  a_r2_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_o == $past(pin_i, 2));

endmodule

// File: rtl/giw_bank_track.sv
module giw_bank_track
  import giw_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lvl_i,
  input  logic [BANK_W-1:0] dir_in_i,
  input  logic [BANK_W-1:0] mask_i,
  input  logic [BANK_W-1:0] inv_i,
  input  logic              rd_i,
  output logic [BANK_W-1:0] data_o,
  output logic              armed_o
);

  logic [BANK_W-1:0]     snap_q;
  logic [GIW_WORD_W-1:0] vis_word;
  logic [GIW_WORD_W-1:0] armed_word;
  logic [BANK_W-1:0]     armed_bits;

  // Reset and a bank read both take the current synchronised levels as the new reference.
  always_ff @(posedge clk) begin
    if (!rst_n || rd_i) begin
      snap_q <= lvl_i;
    end
  end

  always_comb begin
    vis_word   = f_visible(GIW_WORD_W'(lvl_i), GIW_WORD_W'(inv_i));
    armed_word = f_armed(GIW_WORD_W'(lvl_i), GIW_WORD_W'(snap_q),
                         GIW_WORD_W'(dir_in_i), GIW_WORD_W'(mask_i));
    data_o     = vis_word[BANK_W-1:0];
    armed_bits = armed_word[BANK_W-1:0];
  end

  assign armed_o = |armed_bits;

  // R6: a read strobe captures the level present at that edge
  a_r6_read_loads_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (snap_q == $past(lvl_i)));

  // R7: without its own strobe a bank keeps its reference
  a_r7_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(snap_q));

endmodule

// File: rtl/giw_irq_merge.sv
module giw_irq_merge #(
  parameter int unsigned NUM_BANKS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_armed_i,
  output logic                 irq_n_o
);

  logic irq_n_q;

  // The output register stands in for the open-drain driver: 0 pulls low, 1 releases.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= ~|bank_armed_i;
    end
  end

  assign irq_n_o = irq_n_q;

  // R3: any armed bank pulls the line low on the next edge
  a_r3_armed_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_armed_i) |=> !irq_n_o);

endmodule

// File: rtl/pin_watch_irq.sv
module pin_watch_irq #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BANK_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   dir_in_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   mask_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   inv_i,
  input  logic [NUM_BANKS-1:0]          rd_bank_i,
  output logic [NUM_BANKS*BANK_W-1:0]   rd_data_o,
  output logic                          irq_n_o
);

  localparam int unsigned PINS = NUM_BANKS * BANK_W;

  logic [PINS-1:0]      lvl;
  logic [NUM_BANKS-1:0] bank_armed;

  giw_pin_sync #(.WIDTH(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .lvl_o (lvl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    giw_bank_track #(.BANK_W(BANK_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl[b*BANK_W +: BANK_W]),
      .dir_in_i (dir_in_i[b*BANK_W +: BANK_W]),
      .mask_i   (mask_i[b*BANK_W +: BANK_W]),
      .inv_i    (inv_i[b*BANK_W +: BANK_W]),
      .rd_i     (rd_bank_i[b]),
      .data_o   (rd_data_o[b*BANK_W +: BANK_W]),
      .armed_o  (bank_armed[b])
    );
  end

  giw_irq_merge #(.NUM_BANKS(NUM_BANKS)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_armed_i (bank_armed),
    .irq_n_o      (irq_n_o)
  );

  // R4, R5: with every line facing outward or masked, the interrupt stays released
  a_r4_silent_when_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dir_in_i & ~mask_i) == '0) |-> irq_n_o);

endmodule

// File: tb/tb_pin_watch_irq.sv
`timescale 1ns/1ps
module tb_pin_watch_irq;

  localparam int NB = 5;
  localparam int BW = 8;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = 40'hA5_0F_3C_99_42;
  logic [NP-1:0] dir_in_i = '1;
  logic [NP-1:0] mask_i = '0;
  logic [NP-1:0] inv_i = '0;
  logic [NB-1:0] rd_bank_i = '0;
  logic [NP-1:0] rd_data_o;
  logic          irq_n_o;

  pin_watch_irq #(.NUM_BANKS(NB), .BANK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_in_i(dir_in_i),
    .mask_i(mask_i), .inv_i(inv_i), .rd_bank_i(rd_bank_i),
    .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            at;
    logic [NP-1:0] data;
    logic          irq;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Reference model of the requirements
  logic [NP-1:0] m_pin = 40'hA5_0F_3C_99_42;
  logic [NP-1:0] m_snap;
  logic [NP-1:0] m_dir = '1;
  logic [NP-1:0] m_mask = '0;
  logic [NP-1:0] m_inv = '0;
  logic          m_irq = 1'b1;

  function automatic logic [NP-1:0] exp_data();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = m_inv[i] ? !m_pin[i] : m_pin[i];
    return v;
  endfunction

  function automatic logic exp_irq();
    for (int i = 0; i < NP; i++)
      if (m_dir[i] && !m_mask[i] && (m_pin[i] != m_snap[i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic push(input int at, input logic irq, input string tag);
    exp_t e;
    e.at = at; e.data = exp_data(); e.irq = irq; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares queued expectations one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (e.at != cyc) begin
          n_fail++;
          $display("FAIL %s: expectation for cycle %0d missed, now %0d", e.tag, e.at, cyc);
        end else if (rd_data_o !== e.data || irq_n_o !== e.irq) begin
          n_fail++;
          $display("FAIL %s @%0d: data=%h irq_n=%b expected data=%h irq_n=%b",
                   e.tag, cyc, rd_data_o, irq_n_o, e.data, e.irq);
        end
      end
    end
  end

  task automatic change_pins(input logic [NP-1:0] v, input string tag);
    logic old_irq;
    int   c;
    @(negedge clk);
    c = cyc;
    old_irq = m_irq;
    pin_i = v;
    m_pin = v;
    push(c + 2, old_irq, tag);  // new level visible, interrupt not yet moved
    m_irq = exp_irq();
    push(c + 3, m_irq, tag);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bank(input int b, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    rd_bank_i = NB'(1) << b;
    push(c + 1, m_irq, tag);
    @(negedge clk);
    rd_bank_i = '0;
    m_snap[b*BW +: BW] = m_pin[b*BW +: BW];
    m_irq = exp_irq();
    push(c + 2, m_irq, tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [NP-1:0] d, input logic [NP-1:0] m,
                         input logic [NP-1:0] iv, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    dir_in_i = d; mask_i = m; inv_i = iv;
    m_dir = d; m_mask = m; m_inv = iv;
    push(c, m_irq, tag);
    m_irq = exp_irq();
    push(c + 1, m_irq, tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] p;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    m_snap = m_pin;
    m_irq = 1'b1;
    // R9: quiet start, R1: plain read-back
    push(cyc, 1'b1, "R9 reset");
    push(cyc + 3, 1'b1, "R9 after reset");
    repeat (4) @(negedge clk);

    // R2, R3: one input line in bank 0 changes
    p = m_pin; p[3] = ~p[3];
    change_pins(p, "R3 bank0 change");
    // R7: reading another bank keeps the interrupt
    read_bank(1, "R7 foreign read");
    // R6: reading the owning bank releases it
    read_bank(0, "R6 own read");

    // R1: inversion on a mix of bits
    set_cfg(m_dir, m_mask, 40'hFF_00_00_00_F0, "R1 inversion");

    // R4: bank 2 bit 5 set as output toggles silently, still read back
    set_cfg(m_dir & ~(40'd1 << 21), m_mask, m_inv, "R4 make output");
    p = m_pin; p[21] = ~p[21];
    change_pins(p, "R4 output toggle");
    p[21] = ~p[21];
    change_pins(p, "R4 output toggle back");

    // R5: masked line in bank 4, then unmasked while still differing
    set_cfg(m_dir, 40'd1 << 36, m_inv, "R5 mask");
    p = m_pin; p[36] = ~p[36];
    change_pins(p, "R5 masked toggle");
    set_cfg(m_dir, '0, m_inv, "R5 unmask pending");
    read_bank(4, "R6 read bank4");

    // R8: change and revert without a read
    p = m_pin; p[26] = ~p[26];
    change_pins(p, "R8 change");
    p[26] = ~p[26];
    change_pins(p, "R8 revert");

    // R7, R6: two banks pending, cleared one at a time
    p = m_pin; p[9] = ~p[9]; p[38] = ~p[38];
    change_pins(p, "R3 two banks");
    read_bank(1, "R7 first of two");
    read_bank(4, "R6 second of two");

    // R1: full-width pattern with direction mixed (output lines still read back)
    set_cfg(40'h0F_F0_0F_F0_0F, '0, 40'h33_33_33_33_33, "R1 mixed cfg");
    p = 40'h0F_F0_F0_0F_F0;
    m_pin = m_pin; 
    change_pins(p, "R1 pattern");
    for (int b = 0; b < NB; b++) read_bank(b, "R6 sweep");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule